// File: doc/BRIEF.md
# CSR Bus Width Down-Converter

This block sits between a CPU-side port with a wide datapath and a narrow CSR bus. The CPU port is RATIO times the width of the CSR bus, and RATIO is a power of two. Each CPU read or write becomes RATIO back-to-back CSR accesses to consecutive narrow addresses. The converter then returns one acknowledge and, for reads, the assembled wide word.

The downstream CSR multiplexer is configured with a register alignment of RATIO chunks. Two of its rules fix the order in which chunks are issued. Reading chunk 0 of a register captures the whole register into a shadow copy. Writing the last chunk commits the staged value.

For that reason the converter always walks the chunks upward, from offset 0 to offset RATIO-1. Padding chunks get no special handling: the converter issues them like any other chunk and leaves it to the multiplexer to return zero or drop the write.

CSR read data arrives one cycle after its strobe. Reads are therefore pipelined: a new strobe is issued every cycle, and each returning chunk is captured one cycle behind the strobe that requested it.

Top module: `csr_width_downconv`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, csr_rstb, csr_wstb and cpu_ack are all 0.
- R2: An access is accepted on a clock edge where the block is idle and cpu_rd or cpu_wr is 1. If both are 1, the access is a read. cpu_addr and cpu_wdata are latched at acceptance.
- R3: Each accepted access drives exactly RATIO strobes, one per cycle, in the cycles right after acceptance. The strobe in cycle i (i = 0 .. RATIO-1) uses csr_addr = cpu_addr*RATIO + i, which is the latched CPU address concatenated with i.
- R4: On a write, the strobe for chunk i carries bits [i*CSR_DW +: CSR_DW] of the latched write data. Changes on cpu_wdata or cpu_addr after acceptance have no effect.
- R5: On a read, the csr_rdata present in the cycle after the strobe for chunk i is placed into cpu_rdata bits [i*CSR_DW +: CSR_DW].
- R6: cpu_ack is a one-cycle pulse. For a write it comes in the cycle after the last write strobe. For a read it comes two cycles after the last read strobe, and cpu_rdata is valid in that cycle.
- R7: A request presented while an access is in progress, including the acknowledge cycle, is ignored. A request still held in the first idle cycle is accepted then.
- R8: csr_rstb and csr_wstb are never 1 in the same cycle, and neither is 1 while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | CPU_AW | Wide-word address |
| cpu_wdata | input | CSR_DW*RATIO | Wide write data |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_rdata | output | CSR_DW*RATIO | Assembled read data, valid with cpu_ack after a read |
| cpu_ack | output | 1 | One-cycle completion pulse |
| csr_addr | output | CPU_AW+log2(RATIO) | Narrow CSR address |
| csr_rstb | output | 1 | CSR read strobe |
| csr_rdata | input | CSR_DW | CSR read data, valid the cycle after csr_rstb |
| csr_wstb | output | 1 | CSR write strobe |
| csr_wdata | output | CSR_DW | CSR write data chunk |

## Verification
The bench attaches a narrow register file that answers one cycle late. A design that captured read data in the strobe cycle itself would assemble the wrong chunks, shifted by one lane. Requests are held across busy and acknowledge cycles, and cpu_wdata changes mid-transfer, so a design that re-sampled its inputs or accepted a second access early would show extra strobes or corrupted chunks. Simultaneous read and write requests check the read priority. Write-then-read pairs to the same address catch reversed chunk order or misplaced lanes, which would return byte-swapped words.

// File: rtl/csr_width_downconv.sv
module csr_width_downconv #(
  parameter int CPU_AW = 3,
  parameter int CSR_DW = 8,
  parameter int RATIO  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CPU_AW-1:0]                 cpu_addr,
  input  logic [CSR_DW*RATIO-1:0]           cpu_wdata,
  input  logic                              cpu_rd,
  input  logic                              cpu_wr,
  output logic [CSR_DW*RATIO-1:0]           cpu_rdata,
  output logic                              cpu_ack,
  output logic [CPU_AW+$clog2(RATIO)-1:0]   csr_addr,
  output logic                              csr_rstb,
  input  logic [CSR_DW-1:0]                 csr_rdata,
  output logic                              csr_wstb,
  output logic [CSR_DW-1:0]                 csr_wdata
);
  localparam int IW     = $clog2(RATIO);
  localparam int CPU_DW = CSR_DW * RATIO;
  localparam int CSR_AW = CPU_AW + IW;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_DRAIN, S_ACK} state_t;

  state_t            st;
  logic              is_rd;
  logic [CPU_AW-1:0] addr_q;
  logic [CPU_DW-1:0] wdata_q;
  logic [CPU_DW-1:0] rdata_q;
  logic [IW-1:0]     cnt;
  logic [IW-1:0]     samp_i;
  logic              samp_v;
  logic              last;

  assign last      = (cnt == IW'(RATIO - 1));
  assign csr_rstb  = (st == S_ISSUE) &&  is_rd;
  assign csr_wstb  = (st == S_ISSUE) && !is_rd;
  assign csr_addr  = {addr_q, cnt};
  assign csr_wdata = wdata_q[cnt*CSR_DW +: CSR_DW];
  assign cpu_ack   = (st == S_ACK);
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_rd   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_rd || cpu_wr) begin
          st      <= S_ISSUE;
          is_rd   <= cpu_rd;
          addr_q  <= cpu_addr;
          wdata_q <= cpu_wdata;
          cnt     <= '0;
        end
        S_ISSUE: begin
          cnt <= cnt + 1'b1;
          if (last) st <= is_rd ? S_DRAIN : S_ACK;
        end
        S_DRAIN: st <= S_ACK;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_v  <= 1'b0;
      samp_i  <= '0;
      rdata_q <= '0;
    end else begin
      samp_v <= csr_rstb;
      samp_i <= cnt;
      if (samp_v) rdata_q[samp_i*CSR_DW +: CSR_DW] <= csr_rdata;
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_rstb && csr_wstb));
  a_r3_rd_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rstb && $past(csr_rstb)) |-> csr_addr == CSR_AW'($past(csr_addr) + 1'b1));
  a_r3_wr_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wstb && $past(csr_wstb)) |-> csr_addr == CSR_AW'($past(csr_addr) + 1'b1));
  a_r3_first_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(csr_rstb) || $rose(csr_wstb)) |-> csr_addr[IW-1:0] == '0);
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  a_r6_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> ($past(csr_wstb) || $past(csr_rstb, 2)));
  a_r7_no_strobe_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !(csr_rstb || csr_wstb));
endmodule

// File: tb/tb_csr_width_downconv.sv
module tb_csr_width_downconv;
  localparam int CPU_AW = 3, CSR_DW = 8, RATIO = 4;
  localparam int IW = $clog2(RATIO), CPU_DW = CSR_DW*RATIO, CSR_AW = CPU_AW+IW;

  logic clk = 0, rst_n = 0;
  logic [CPU_AW-1:0] cpu_addr = '0;
  logic [CPU_DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_rd = 0, cpu_wr = 0, cpu_ack;
  logic [CSR_AW-1:0] csr_addr;
  logic csr_rstb, csr_wstb;
  logic [CSR_DW-1:0] csr_rdata = '0, csr_wdata;

  csr_width_downconv #(.CPU_AW(CPU_AW), .CSR_DW(CSR_DW), .RATIO(RATIO)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .csr_addr(csr_addr), .csr_rstb(csr_rstb), .csr_rdata(csr_rdata),
    .csr_wstb(csr_wstb), .csr_wdata(csr_wdata));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [CSR_DW-1:0] mem [2**CSR_AW];

  bit m_busy = 0, m_rd = 0;
  int m_step = 0;
  logic [CPU_AW-1:0] m_a;
  logic [CPU_DW-1:0] m_wd;

  bit l_rst, l_rd, l_wr, l_rs, l_ws;
  logic [CPU_AW-1:0] l_addr;
  logic [CPU_DW-1:0] l_wd;
  logic [CSR_AW-1:0] l_ca;
  logic [CSR_DW-1:0] l_cw;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_rs, e_ws, e_ack;
    logic [CPU_DW-1:0] e_rd;
    e_rs  = m_busy && m_rd  && m_step < RATIO;
    e_ws  = m_busy && !m_rd && m_step < RATIO;
    e_ack = m_busy && (m_rd ? m_step == RATIO+1 : m_step == RATIO);
    if (!done) begin
      if (!rst_n) begin
        chk(!csr_rstb && !csr_wstb && !cpu_ack, "R1 reset outputs",
            {csr_rstb, csr_wstb, cpu_ack}, 0);
      end else begin
        chk(csr_rstb == e_rs, "R2 R7 R8 read strobe", csr_rstb, e_rs);
        chk(csr_wstb == e_ws, "R2 R7 R8 write strobe", csr_wstb, e_ws);
        chk(cpu_ack == e_ack, "R6 ack timing", cpu_ack, e_ack);
        if (e_rs || e_ws)
          chk(csr_addr == {m_a, IW'(m_step)}, "R3 chunk address", csr_addr, {m_a, IW'(m_step)});
        if (e_ws)
          chk(csr_wdata == m_wd[m_step*CSR_DW +: CSR_DW], "R4 write chunk data",
              csr_wdata, m_wd[m_step*CSR_DW +: CSR_DW]);
        if (e_ack && m_rd) begin
          for (int i = 0; i < RATIO; i++) e_rd[i*CSR_DW +: CSR_DW] = mem[{m_a, IW'(i)}];
          chk(cpu_rdata == e_rd, "R5 assembled read data", cpu_rdata, e_rd);
        end
      end
    end
    l_rst = !rst_n; l_rd = cpu_rd; l_wr = cpu_wr; l_addr = cpu_addr; l_wd = cpu_wdata;
    l_rs = csr_rstb; l_ws = csr_wstb; l_ca = csr_addr; l_cw = csr_wdata;
  end

  always @(posedge clk) begin
    if (l_ws) mem[l_ca] = l_cw;
    if (l_rs) csr_rdata <= mem[l_ca];
    if (l_rst) begin
      m_busy = 0; m_step = 0;
    end else if (!m_busy) begin
      if (l_rd || l_wr) begin
        m_busy = 1; m_rd = l_rd; m_a = l_addr; m_wd = l_wd; m_step = 0;
      end
    end else if ((m_rd && m_step == RATIO+1) || (!m_rd && m_step == RATIO)) begin
      m_busy = 0;
    end else begin
      m_step++;
    end
  end

  task automatic drive(input bit rd, input bit wr, input int a, input logic [CPU_DW-1:0] d);
    @(posedge clk); #2;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = CPU_AW'(a); cpu_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, '0);
  endtask

  initial begin
    for (int i = 0; i < 2**CSR_AW; i++) mem[i] = CSR_DW'(i*37 + 5);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    idle(2);
    drive(0, 1, 2, 32'h11223344); idle(8);
    drive(1, 0, 2, '0); idle(8);
    drive(1, 1, 5, 32'hdeadbeef); idle(8);
    drive(0, 1, 7, 32'ha5a55a5a);
    for (int i = 0; i < 6; i++) drive(0, 1, i, 32'(i*32'h01010101));
    drive(1, 0, 7, '0);
    for (int i = 0; i < 10; i++) drive(1, 0, 3, '0);
    idle(6);
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 8;
      drive(r == 0 || r == 2, r == 1 || r == 2 || r == 3, $urandom, $urandom);
    end
    idle(10);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog expired: actual hung expected finished");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule